// File: doc/BRIEF.md
# I2C Bus Master Timing Engine

This block is a single-master I2C bus controller. It produces the bus clock and data through two drive-low enables: a 1 on an enable pulls the wire low, and a 0 releases it to the external pull-up. Every interval is counted in system clock cycles. A programmed period value gives both the SCL low time and the SCL high time. The same logic therefore runs a standard-rate bus (100 kbps) or a fast-rate bus (400 kbps), depending only on the value the integrator writes.

A host drives a one-cycle command interface. There are four commands: START (also used as a repeated START), WRITE a byte with acknowledge sampling, READ a byte with a selectable ACK or NACK reply, and STOP. A command runs with `busy` high. At the end, a one-cycle `done` pulse is given. Between commands, while the bus is owned, SCL is held low. The fixed setup intervals for START and STOP do not follow the bit period, so their parameters apply at every bus rate.

Top module: `i2c_timing_master`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, both drive-low enables are 0, `busy` is 0 and `done` is 0.
- R2: The effective period P is `period_cfg`, or MIN_PERIOD (4) if `period_cfg` is smaller. Each data bit has an SCL-low phase of P cycles followed by an SCL-released phase of P cycles.
- R3: Within a bit, SDA keeps its previous level for floor(P/2) cycles of the low phase and then switches to the new level. SDA does not change while SCL is released during a data bit.
- R4: START from the idle bus keeps both lines released for START_SETUP (36) cycles. It then drives SDA low with SCL released for P cycles, and then drives SCL low.
- R5: START while the bus is owned first releases SDA with SCL low for floor(P/2) cycles, then follows the R4 sequence.
- R6: STOP drives SDA low with SCL low for floor(P/2) cycles. It then releases SCL for STOP_SETUP (24) cycles with SDA still low, and then releases SDA, which leaves the bus idle.
- R7: WRITE sends `cmd_wdata` MSB first, with `sda_drive_low`=1 for a 0 bit, and releases SDA during the ninth bit. In the last cycle of the ninth SCL-released phase it samples the line into `ack_nack` (1 = NACK).
- R8: READ releases SDA for eight bits. It samples the line in the last cycle of each SCL-released phase, MSB first, into `rd_data`. In the ninth bit it drives SDA low if `cmd_nack`=0 and releases it if `cmd_nack`=1.
- R9: `cmd_op` encoding: 0 START, 1 WRITE, 2 READ, 3 STOP. A command is accepted when `cmd_valid` is high and `busy` is low. `busy` is high from the cycle after acceptance through the last timed cycle. `done` is high for exactly one cycle, with `busy` low, in the cycle after that.
- R10: The bus ignores WRITE, READ or STOP while it is idle, and ignores any command while `busy` is high. No `busy`, no `done` and no line change follow from such a command.
- R11: The effective period is captured when a command is accepted. A change to `period_cfg` during a command does not alter its timing.
- R12: Between commands, SCL stays low while the bus is owned, and SDA keeps the level it had when the previous command finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command code (R9 encoding) |
| cmd_wdata | input | 8 | Byte to send on WRITE |
| cmd_nack | input | 1 | READ reply: 1 = NACK, 0 = ACK |
| period_cfg | input | CW (12) | SCL low/high time in system clocks |
| sda_in | input | 1 | Sensed SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte sampled from the line in the last byte command |
| ack_nack | output | 1 | Acknowledge sampled after the last WRITE (1 = NACK) |

## Verification
The assertions check, on every cycle, the properties that hold at all times. `done` never lasts two cycles and never coincides with `busy`. SDA holds still while SCL is released inside a data bit. The lines are steady between commands. A counter confirms the START and STOP setup windows before each SDA edge made with SCL released. The bench's reference model, compared every clock, is the only check on the exact phase lengths for odd, clamped and changed periods, on the position of the midpoint data change, on the bit order and on the bytes and acknowledges captured. It also shows that ignored commands leave the bus untouched.

// File: rtl/i2c_tm_pkg.sv
package i2c_tm_pkg;

   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2,
      OP_STOP  = 2'd3
   } op_e;

   typedef enum logic [3:0] {
      PH_IDLE,    // bus free, both lines released
      PH_OWN,     // bus owned, SCL held low between commands
      PH_SREL,    // repeated start: SDA released, SCL low
      PH_SSETUP,  // start setup: both released
      PH_SHOLD,   // start hold: SDA low, SCL released
      PH_PLOW,    // stop: SDA low, SCL low
      PH_PSETUP,  // stop setup: SDA low, SCL released
      PH_LOWA,    // bit low phase, before midpoint
      PH_LOWB,    // bit low phase, after midpoint
      PH_HIGH     // bit high phase
   } phase_e;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_tm_period.sv
module i2c_tm_period #(
   parameter int CW         = 12,
   parameter int MIN_PERIOD = 4,
   parameter bit LATCH      = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] cfg,
   output logic [CW-1:0] per_now,
   output logic [CW-1:0] per_run
);

   localparam logic [CW-1:0] MIN_V = CW'(MIN_PERIOD);

   if (MIN_PERIOD < 4) begin : g_bad_min
      $error("MIN_PERIOD must be at least 4");
   end
   if (MIN_PERIOD >= (1 << CW)) begin : g_bad_cw
      $error("CW too narrow for MIN_PERIOD");
   end

   assign per_now = (cfg < MIN_V) ? MIN_V : cfg;

   generate
      if (LATCH) begin : g_latch
         logic [CW-1:0] per_q;
         always_ff @(posedge clk) begin
            if (rst)       per_q <= MIN_V;
            else if (load) per_q <= per_now;
         end
         assign per_run = per_q;
      end else begin : g_live
         assign per_run = per_now;
      end
   endgenerate

endmodule

// File: rtl/i2c_tm_timer.sv
module i2c_tm_timer #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)               cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/i2c_tm_shift.sv
module i2c_tm_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         shift,
   input  logic         bit_in,
   output logic         msb,
   output logic [W-1:0] q
);

   if (W < 2) begin : g_bad_w
      $error("shift width must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (load)  q <= din;
      else if (shift) q <= {q[W-2:0], bit_in};
   end

   assign msb = q[W-1];

endmodule

// File: rtl/i2c_timing_master.sv
module i2c_timing_master #(
   parameter int CW          = 12,
   parameter int MIN_PERIOD  = 4,
   parameter int START_SETUP = 36,
   parameter int STOP_SETUP  = 24,
   parameter bit LATCH_PER   = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cmd_valid,
   input  logic [1:0]    cmd_op,
   input  logic [7:0]    cmd_wdata,
   input  logic          cmd_nack,
   input  logic [CW-1:0] period_cfg,
   input  logic          sda_in,
   output logic          scl_drive_low,
   output logic          sda_drive_low,
   output logic          busy,
   output logic          done,
   output logic [7:0]    rd_data,
   output logic          ack_nack
);
   import i2c_tm_pkg::*;

   localparam logic [CW-1:0] START_LD = CW'(START_SETUP - 1);
   localparam logic [CW-1:0] STOP_LD  = CW'(STOP_SETUP - 1);
   localparam int            SAT_W    = 8;
   localparam logic [3:0]    LAST_BIT = 4'(BYTE_W);

   if (START_SETUP < 1 || START_SETUP >= (1 << CW) || START_SETUP > 255) begin : g_bad_ss
      $error("START_SETUP out of range");
   end
   if (STOP_SETUP < 1 || STOP_SETUP >= (1 << CW) || STOP_SETUP > 255) begin : g_bad_ps
      $error("STOP_SETUP out of range");
   end

   phase_e        ph, ph_nx;
   logic [3:0]    bitn;
   logic          sda_q, sda_nx;
   logic          done_q, is_rd, rd_nack_q, nack_q;
   logic          accept, fin, tmr_ld, shf, shl;
   logic [CW-1:0] tmr_val, per_now, per_run, half_now, half_run;
   logic          expired, sh_msb, bit_val;
   logic [7:0]    sh_q;
   op_e           op;

   assign op = op_e'(cmd_op);

   i2c_tm_period #(.CW(CW), .MIN_PERIOD(MIN_PERIOD), .LATCH(LATCH_PER)) u_per (
      .clk(clk), .rst(rst), .load(accept), .cfg(period_cfg),
      .per_now(per_now), .per_run(per_run));

   i2c_tm_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst(rst), .load(tmr_ld), .load_val(tmr_val), .expired(expired));

   i2c_tm_shift #(.W(BYTE_W)) u_sh (
      .clk(clk), .rst(rst), .load(shl), .din(cmd_wdata), .shift(shf),
      .bit_in(sda_in), .msb(sh_msb), .q(sh_q));

   assign half_now = per_now >> 1;
   assign half_run = per_run >> 1;

   // level for the current bit: data bits, then acknowledge slot
   always_comb begin
      if (bitn < LAST_BIT) bit_val = is_rd ? 1'b0 : ~sh_msb;
      else                 bit_val = is_rd ? ~rd_nack_q : 1'b0;
   end

   always_comb begin
      ph_nx   = ph;
      tmr_ld  = 1'b0;
      tmr_val = '0;
      sda_nx  = sda_q;
      shf     = 1'b0;
      shl     = 1'b0;
      fin     = 1'b0;
      accept  = cmd_valid && ((ph == PH_OWN) || (ph == PH_IDLE && op == OP_START));
      unique case (ph)
         PH_IDLE, PH_OWN: if (accept) begin
            tmr_ld = 1'b1;
            unique case (op)
               OP_START: begin
                  sda_nx = 1'b0;
                  if (ph == PH_OWN) begin ph_nx = PH_SREL;   tmr_val = half_now - 1'b1; end
                  else              begin ph_nx = PH_SSETUP; tmr_val = START_LD;        end
               end
               OP_STOP: begin ph_nx = PH_PLOW; tmr_val = half_now - 1'b1; sda_nx = 1'b1; end
               default: begin ph_nx = PH_LOWA; tmr_val = half_now - 1'b1; shl = 1'b1; end
            endcase
         end
         PH_SREL:   if (expired) begin ph_nx = PH_SSETUP; tmr_ld = 1'b1; tmr_val = START_LD; end
         PH_SSETUP: if (expired) begin
            ph_nx = PH_SHOLD; tmr_ld = 1'b1; tmr_val = per_run - 1'b1; sda_nx = 1'b1;
         end
         PH_SHOLD:  if (expired) begin ph_nx = PH_OWN; fin = 1'b1; end
         PH_PLOW:   if (expired) begin ph_nx = PH_PSETUP; tmr_ld = 1'b1; tmr_val = STOP_LD; end
         PH_PSETUP: if (expired) begin ph_nx = PH_IDLE; sda_nx = 1'b0; fin = 1'b1; end
         PH_LOWA:   if (expired) begin
            ph_nx = PH_LOWB; tmr_ld = 1'b1; tmr_val = per_run - half_run - 1'b1; sda_nx = bit_val;
         end
         PH_LOWB:   if (expired) begin ph_nx = PH_HIGH; tmr_ld = 1'b1; tmr_val = per_run - 1'b1; end
         PH_HIGH:   if (expired) begin
            if (bitn < LAST_BIT) begin
               shf = 1'b1; ph_nx = PH_LOWA; tmr_ld = 1'b1; tmr_val = half_run - 1'b1;
            end else begin
               ph_nx = PH_OWN; fin = 1'b1;
            end
         end
         default: ph_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph        <= PH_IDLE;
         bitn      <= '0;
         sda_q     <= 1'b0;
         done_q    <= 1'b0;
         is_rd     <= 1'b0;
         rd_nack_q <= 1'b0;
         nack_q    <= 1'b0;
      end else begin
         ph     <= ph_nx;
         sda_q  <= sda_nx;
         done_q <= fin;
         if (accept) begin
            bitn      <= '0;
            is_rd     <= (op == OP_READ);
            rd_nack_q <= cmd_nack;
         end else if (ph == PH_HIGH && expired) begin
            bitn <= bitn + 1'b1;
            if (bitn == LAST_BIT && !is_rd) nack_q <= sda_in;
         end
      end
   end

   assign scl_drive_low = (ph == PH_OWN) || (ph == PH_SREL) || (ph == PH_PLOW) ||
                          (ph == PH_LOWA) || (ph == PH_LOWB);
   assign sda_drive_low = sda_q;
   assign busy          = (ph != PH_IDLE) && (ph != PH_OWN);
   assign done          = done_q;
   assign rd_data       = sh_q;
   assign ack_nack      = nack_q;

   // window counters for the setup checks
   logic [SAT_W-1:0] rel_cnt, hi_cnt;
   always_ff @(posedge clk) begin
      if (rst) begin
         rel_cnt <= '0;
         hi_cnt  <= '0;
      end else begin
         if (scl_drive_low || sda_drive_low) rel_cnt <= '0;
         else if (rel_cnt != '1)             rel_cnt <= rel_cnt + 1'b1;
         if (scl_drive_low || !sda_drive_low) hi_cnt <= '0;
         else if (hi_cnt != '1)               hi_cnt <= hi_cnt + 1'b1;
      end
   end

   AST_START_SETUP: assert property (@(posedge clk) disable iff (rst)
      ($rose(sda_drive_low) && !scl_drive_low) |-> (rel_cnt >= SAT_W'(START_SETUP))); // R4
   AST_STOP_SETUP: assert property (@(posedge clk) disable iff (rst)
      ($fell(sda_drive_low) && !scl_drive_low) |-> (hi_cnt >= SAT_W'(STOP_SETUP))); // R6
   AST_SDA_STILL_HIGH: assert property (@(posedge clk) disable iff (rst)
      (ph == PH_HIGH && $past(ph) == PH_HIGH) |-> $stable(sda_drive_low)); // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R9
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy); // R9
   AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
      (!busy && $past(!busy)) |-> ($stable(scl_drive_low) && $stable(sda_drive_low))); // R12

endmodule

// File: tb/tb_i2c_timing_master.sv
module tb_i2c_timing_master;
   localparam int CLK_PERIOD = 10;
   localparam int CW         = 12;
   localparam int SS         = 36;
   localparam int PS         = 24;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'd0;
   logic [7:0]    cmd_wdata = 8'h00;
   logic          cmd_nack = 1'b0;
   logic [CW-1:0] period_cfg = CW'(8);
   logic          slave_pull = 1'b0;
   logic          sda_in;
   logic          scl_drive_low, sda_drive_low, busy, done, ack_nack;
   logic [7:0]    rd_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_in = ~(sda_drive_low | slave_pull);

   i2c_timing_master dut (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack), .period_cfg(period_cfg),
      .sda_in(sda_in), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
      .busy(busy), .done(done), .rd_data(rd_data), .ack_nack(ack_nack));

   typedef struct packed { bit scl; bit sda; bit bsy; bit dn; bit slv; } ent_t;
   ent_t  q[$];
   int    errs = 0;
   int    checks = 0;
   bit    m_owned = 1'b0;
   bit    m_sda = 1'b0;
   string cur_tag = "R1";

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s t=%0t act=%0h exp=%0h", req, $time, act, exp);
      end
   endtask

   task automatic push(int n, bit scl, bit sda, bit bsy, bit dn, bit slv);
      for (int i = 0; i < n; i++) q.push_back('{scl, sda, bsy, dn, slv});
   endtask

   // one cycle of the reference model, compared away from the active edge
   task automatic tick();
      ent_t  e;
      string tg;
      @(negedge clk);
      if (q.size() > 0) begin e = q.pop_front(); tg = cur_tag; end
      else begin e = '{m_owned, m_sda, 1'b0, 1'b0, 1'b0}; tg = "R12"; end
      chk(tg, {31'd0, scl_drive_low}, {31'd0, e.scl});
      chk(tg, {31'd0, sda_drive_low}, {31'd0, e.sda});
      chk("R9", {31'd0, busy}, {31'd0, e.bsy});
      chk("R9", {31'd0, done}, {31'd0, e.dn});
      slave_pull = e.slv;
   endtask

   // op: 0 START 1 WRITE 2 READ 3 STOP
   task automatic do_cmd(int op, bit [7:0] data, bit nack, bit slv_ack, bit [7:0] rdb,
                         int cfg_mid, bit poke, string tag);
      int  p, h;
      bit  acc, prev, d, s;
      p   = (int'(period_cfg) < 4) ? 4 : int'(period_cfg);
      h   = p / 2;
      acc = (op == 0) || m_owned;
      cur_tag   = tag;
      cmd_valid = 1'b1;
      cmd_op    = 2'(op);
      cmd_wdata = data;
      cmd_nack  = nack;
      if (acc) begin
         if (op == 0) begin
            if (m_owned) push(h, 1, 0, 1, 0, 0);
            push(SS, 0, 0, 1, 0, 0);
            push(p, 0, 1, 1, 0, 0);
            push(1, 1, 1, 0, 1, 0);
            m_owned = 1'b1; m_sda = 1'b1;
         end else if (op == 3) begin
            push(h, 1, 1, 1, 0, 0);
            push(PS, 0, 1, 1, 0, 0);
            push(1, 0, 0, 0, 1, 0);
            m_owned = 1'b0; m_sda = 1'b0;
         end else begin
            prev = m_sda;
            for (int i = 0; i < 9; i++) begin
               if (op == 1) begin d = (i < 8) ? ~data[7-i] : 1'b0; s = (i < 8) ? 1'b0 : slv_ack; end
               else         begin d = (i < 8) ? 1'b0 : ~nack;      s = (i < 8) ? ~rdb[7-i] : 1'b0; end
               push(h, 1, prev, 1, 0, s);
               push(p - h, 1, d, 1, 0, s);
               push(p, 0, d, 1, 0, s);
               prev = d;
            end
            push(1, 1, prev, 0, 1, 0);
            m_sda = prev;
         end
      end
      tick();
      cmd_valid = 1'b0;
      if (cfg_mid >= 0) period_cfg = CW'(cfg_mid);
      while (q.size() > 0) begin
         tick();
         if (poke && q.size() == 12) begin cmd_valid = 1'b1; cmd_op = 2'd3; end
         else cmd_valid = 1'b0;
      end
      cmd_valid = 1'b0;
      tick();
      tick();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) tick();
      @(negedge clk);
      chk("R1", {28'd0, scl_drive_low, sda_drive_low, busy, done}, 32'd0);
      rst = 1'b0;
      tick();
      chk("R1", {28'd0, scl_drive_low, sda_drive_low, busy, done}, 32'd0);

      period_cfg = CW'(8);
      do_cmd(1, 8'hFF, 0, 0, 8'h00, -1, 0, "R10");   // write on idle bus
      do_cmd(2, 8'h00, 0, 0, 8'h00, -1, 0, "R10");   // read on idle bus
      do_cmd(3, 8'h00, 0, 0, 8'h00, -1, 0, "R10");   // stop on idle bus

      do_cmd(0, 8'h00, 0, 0, 8'h00, -1, 0, "R4");
      do_cmd(1, 8'hA5, 0, 1, 8'h00, -1, 0, "R2 R3 R7");
      chk("R7", {24'd0, rd_data}, 32'hA5);
      chk("R7", {31'd0, ack_nack}, 32'd0);

      do_cmd(1, 8'h3C, 0, 0, 8'h00, 20, 0, "R7 R11");
      chk("R7", {31'd0, ack_nack}, 32'd1);
      chk("R7", {24'd0, rd_data}, 32'h3C);

      period_cfg = CW'(7);
      do_cmd(0, 8'h00, 0, 0, 8'h00, -1, 0, "R5");
      do_cmd(2, 8'h00, 0, 0, 8'h96, -1, 0, "R3 R8");
      chk("R8", {24'd0, rd_data}, 32'h96);

      period_cfg = CW'(2);
      do_cmd(2, 8'h00, 1, 0, 8'h5A, -1, 1, "R2 R8 R10");
      chk("R8", {24'd0, rd_data}, 32'h5A);

      period_cfg = CW'(5);
      do_cmd(1, 8'h01, 0, 1, 8'h00, -1, 0, "R3 R7");
      chk("R7", {31'd0, ack_nack}, 32'd0);
      do_cmd(3, 8'h00, 0, 0, 8'h00, -1, 0, "R6");
      do_cmd(1, 8'h55, 0, 0, 8'h00, -1, 0, "R10");   // bus idle again
      do_cmd(0, 8'h00, 0, 0, 8'h00, -1, 0, "R4");
      do_cmd(3, 8'h00, 0, 0, 8'h00, -1, 0, "R6");

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule